// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller governs a static memory whose every cell has a nonvolatile shadow. It chooses when the whole array is copied into the shadow (a store) and when the shadow is copied back into the array (a recall). Its inputs are three things: two digitised supply flags, the sensed level of a shared open-drain request/busy line, and a dirty flag raised by the memory port on every completed write. Its outputs are the copy commands, a port-disable signal, the pull-down for the shared line, and a one-cycle strobe that clears the dirty flag. Copies are modelled as level pulses of fixed cycle counts. Every duration is a parameter.

A store has two possible triggers. One is another agent pulling the shared line low. The other is the supply falling below the switch level. A store is skipped when nothing was written since the last copy. When the supply falls, the line is pulled low during a grace window. If the sensed line stays high, some agent is overriding the pull and the attempt is dropped. A recall request is latched whenever the supply is below the reset level, and that request runs once the supply is back above the switch level.

States: POWER_OFF (port disabled, waiting for supply), RECALL (shadow copied into array), IDLE (normal access), GRACE (in-flight access allowed to finish), STORE (array copied to shadow, line held low), WAIT_RELEASE (port held off until the line has been high for the recovery time). Transitions:
- POWER_OFF goes to RECALL when the supply is back and a recall is pending. It goes to IDLE when the supply is back and no recall is pending.
- RECALL goes to IDLE when its count ends.
- IDLE goes to GRACE on a supply drop or a line request. It goes to POWER_OFF on a supply drop while auto-store is inhibited.
- GRACE goes to STORE when the dirty flag is set. It goes to WAIT_RELEASE for a line request with no store. It goes to POWER_OFF for a supply-triggered attempt that was aborted or found nothing to store.
- STORE goes to POWER_OFF for a supply-triggered store and to WAIT_RELEASE for a line-triggered store.
- WAIT_RELEASE goes to IDLE after the recovery time. It goes to POWER_OFF if the supply is lost.

Top module: `nv_backup_sequencer`

## Requirements
- R1: After reset the block sits in POWER_OFF with a recall pending. port_off is 1, and busy_pull, store_active, recall_active and dirty_clr are all 0.
- R2: In POWER_OFF, a cycle with supply_ok=1 and a recall pending leads to RECALL at the next edge. recall_active stays 1 for exactly RECALL_CYC cycles with port_off=1. After that the block is in IDLE with port_off=0. A store and a recall are never active together.
- R3: Any cycle with supply_dead=1 latches a recall request, and starting a recall clears it. A supply dip that keeps supply_dead at 0 returns to IDLE without a recall.
- R4: dirty_clr is 1 for exactly the first cycle of each STORE and each RECALL, and is 0 otherwise.
- R5: In IDLE with supply_ok=1, a sensed busy_in=0 leads to GRACE for GRACE_CYC cycles. During GRACE port_off=0 and busy_pull=0.
- R6: A store starts only when dirty=1 in the last GRACE cycle. store_active then stays 1 for exactly STORE_CYC cycles, with busy_pull=1 and port_off=1.
- R7: A line-triggered request enters WAIT_RELEASE after the store, or directly when there is no store. port_off stays 1 until busy_in has been 1 for RECOVER_CYC consecutive cycles, and the block then enters IDLE.
- R8: A supply drop (supply_ok=0) in IDLE with autostore_off=0 enters GRACE with busy_pull=1 for GRACE_CYC cycles. A store follows when dirty=1. Otherwise the line is released and the block enters POWER_OFF.
- R9: On a supply-triggered attempt, if busy_in is still 1 in the last GRACE cycle, no store runs and the block enters POWER_OFF.
- R10: With autostore_off=1, a supply drop in IDLE goes straight to POWER_OFF with no pull-down and no store.
- R11: While supply_ok=0, a low busy_in starts no store.
- R12: If a supply drop and a line request reach IDLE in the same cycle, the supply-triggered path is taken, so busy_pull is 1 during GRACE.
- R13: After a supply-triggered store completes, the block is in POWER_OFF with port_off=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above switch level |
| supply_dead | input | 1 | Supply below reset level |
| autostore_off | input | 1 | Disables supply-triggered stores |
| busy_in | input | 1 | Sensed level of shared open-drain line (0 = low) |
| dirty | input | 1 | A write happened since the last copy |
| busy_pull | output | 1 | Pull-down enable for the shared line |
| port_off | output | 1 | Disables the memory port |
| store_active | output | 1 | Array-to-shadow copy in progress |
| recall_active | output | 1 | Shadow-to-array copy in progress |
| dirty_clr | output | 1 | One-cycle clear strobe for the dirty flag |

## Verification
The bench builds the block with GRACE_CYC=4, STORE_CYC=12, RECALL_CYC=8 and RECOVER_CYC=3. With these values every full store, recall and recovery window fits in a few dozen cycles, while the real-time defaults would need millions. These short counts make it cheap to reach the abort path (the line is held high against the pull) and the same-cycle trigger collision. They also allow an inhibited-auto-store dip followed by a deep drop, and a line request made while the supply is low. All of these run inside one short run, and a per-cycle model compares every output on every edge.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        NVS_POWER_OFF    = 3'd0,
        NVS_RECALL       = 3'd1,
        NVS_IDLE         = 3'd2,
        NVS_GRACE        = 3'd3,
        NVS_STORE        = 3'd4,
        NVS_WAIT_RELEASE = 3'd5
    } nvs_state_e;

    function automatic int nvs_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/nvs_down_timer.sv
module nvs_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvs_recall_flag.sv
module nvs_recall_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    // Power-up counts as a deep supply loss: a recall is pending from reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b1;
        end else if (set_i) begin
            pend_o <= 1'b1;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end
    end

endmodule

// File: rtl/nv_backup_sequencer.sv
module nv_backup_sequencer
    import nvs_pkg::*;
#(
    parameter int GRACE_CYC   = 125,
    parameter int STORE_CYC   = 1250000,
    parameter int RECALL_CYC  = 68750,
    parameter int RECOVER_CYC = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic supply_dead,
    input  logic autostore_off,
    input  logic busy_in,
    input  logic dirty,
    output logic busy_pull,
    output logic port_off,
    output logic store_active,
    output logic recall_active,
    output logic dirty_clr
);

    localparam int MAX_CYC = nvs_max4(GRACE_CYC, STORE_CYC, RECALL_CYC, RECOVER_CYC);
    localparam int CW      = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] GRACE_LD   = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] STORE_LD   = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RECALL_LD  = CW'(RECALL_CYC - 1);
    localparam logic [CW-1:0] RECOVER_LD = CW'(RECOVER_CYC - 1);

    nvs_state_e    state_q, state_d;
    logic          src_supply_q, src_supply_d;
    logic          clr_q, clr_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          rq_pend;
    logic          rq_clr;

    nvs_down_timer #(.W(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    nvs_recall_flag recall_flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (supply_dead),
        .clr_i  (rq_clr),
        .pend_o (rq_pend)
    );

    // Next-state and timer control
    always_comb begin
        state_d      = state_q;
        src_supply_d = src_supply_q;
        clr_d        = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        rq_clr       = 1'b0;
        unique case (state_q)
            NVS_POWER_OFF: begin
                if (supply_ok) begin
                    if (rq_pend) begin
                        state_d  = NVS_RECALL;
                        tmr_load = 1'b1;
                        tmr_val  = RECALL_LD;
                        rq_clr   = 1'b1;
                        clr_d    = 1'b1;
                    end else begin
                        state_d = NVS_IDLE;
                    end
                end
            end
            NVS_RECALL: begin
                if (tmr_done) state_d = NVS_IDLE;
            end
            NVS_IDLE: begin
                if (!supply_ok) begin
                    if (!autostore_off) begin
                        state_d      = NVS_GRACE;
                        src_supply_d = 1'b1;
                        tmr_load     = 1'b1;
                        tmr_val      = GRACE_LD;
                    end else begin
                        state_d = NVS_POWER_OFF;
                    end
                end else if (!busy_in) begin
                    state_d      = NVS_GRACE;
                    src_supply_d = 1'b0;
                    tmr_load     = 1'b1;
                    tmr_val      = GRACE_LD;
                end
            end
            NVS_GRACE: begin
                if (tmr_done) begin
                    if (src_supply_q && busy_in) begin
                        state_d = NVS_POWER_OFF;
                    end else if (dirty) begin
                        state_d  = NVS_STORE;
                        tmr_load = 1'b1;
                        tmr_val  = STORE_LD;
                        clr_d    = 1'b1;
                    end else if (src_supply_q) begin
                        state_d = NVS_POWER_OFF;
                    end else begin
                        state_d  = NVS_WAIT_RELEASE;
                        tmr_load = 1'b1;
                        tmr_val  = RECOVER_LD;
                    end
                end
            end
            NVS_STORE: begin
                if (tmr_done) begin
                    if (src_supply_q) begin
                        state_d = NVS_POWER_OFF;
                    end else begin
                        state_d  = NVS_WAIT_RELEASE;
                        tmr_load = 1'b1;
                        tmr_val  = RECOVER_LD;
                    end
                end
            end
            NVS_WAIT_RELEASE: begin
                if (!supply_ok) begin
                    state_d = NVS_POWER_OFF;
                end else if (!busy_in) begin
                    tmr_load = 1'b1;
                    tmr_val  = RECOVER_LD;
                end else if (tmr_done) begin
                    state_d = NVS_IDLE;
                end
            end
            default: state_d = NVS_POWER_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= NVS_POWER_OFF;
            src_supply_q <= 1'b0;
            clr_q        <= 1'b0;
        end else begin
            state_q      <= state_d;
            src_supply_q <= src_supply_d;
            clr_q        <= clr_d;
        end
    end

    // Outputs
    always_comb begin
        port_off      = 1'b0;
        busy_pull     = 1'b0;
        store_active  = 1'b0;
        recall_active = 1'b0;
        dirty_clr     = clr_q;
        unique case (state_q)
            NVS_POWER_OFF:    port_off = 1'b1;
            NVS_RECALL: begin
                port_off      = 1'b1;
                recall_active = 1'b1;
            end
            NVS_IDLE:         port_off = 1'b0;
            NVS_GRACE:        busy_pull = src_supply_q;
            NVS_STORE: begin
                port_off     = 1'b1;
                store_active = 1'b1;
                busy_pull    = 1'b1;
            end
            NVS_WAIT_RELEASE: port_off = 1'b1;
            default:          port_off = 1'b1;
        endcase
    end

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter int STORE_CYC = 12
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic dirty,
    input logic port_off,
    input logic store_active,
    input logic recall_active,
    input logic dirty_clr
);

    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_len <= 0;
        else if (store_active) run_len <= run_len + 1;
        else                   run_len <= 0;
    end

    assert_store_needs_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_active) |-> $past(dirty));

    assert_store_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(store_active) |-> (run_len == STORE_CYC));

    assert_clear_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(store_active) || $rose(recall_active)) |-> dirty_clr);

    assert_clear_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_clr |=> !dirty_clr);

    assert_one_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_active, recall_active}));

    assert_recall_needs_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_active) |-> $past(supply_ok));

    assert_held_after_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(store_active) |-> port_off);

endmodule

bind nv_backup_sequencer nvs_checker #(.STORE_CYC(STORE_CYC)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .dirty         (dirty),
    .port_off      (port_off),
    .store_active  (store_active),
    .recall_active (recall_active),
    .dirty_clr     (dirty_clr)
);

// File: tb/nv_backup_sequencer_tb_top.sv
module nv_backup_sequencer_tb_top;

    localparam int GR = 4;
    localparam int ST = 12;
    localparam int RC = 8;
    localparam int RV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, supply_dead = 1'b0, autostore_off = 1'b0;
    logic ext_low = 1'b0, hold_high = 1'b0;
    logic dirty = 1'b0;
    logic busy_pull, port_off, store_active, recall_active, dirty_clr;
    logic busy_line;

    int checks = 0, errors = 0;
    bit run = 0;
    int n_store = 0, n_recall = 0, n_pull = 0, n_clr = 0;

    // reference model variables
    int m_ph = 0, m_left = 0;
    bit m_src = 0, m_rq = 1, m_clr = 0;

    always #4 clk = ~clk;

    assign busy_line = !(ext_low || (busy_pull && !hold_high));

    nv_backup_sequencer #(
        .GRACE_CYC(GR), .STORE_CYC(ST), .RECALL_CYC(RC), .RECOVER_CYC(RV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .supply_dead(supply_dead),
        .autostore_off(autostore_off), .busy_in(busy_line), .dirty(dirty),
        .busy_pull(busy_pull), .port_off(port_off), .store_active(store_active),
        .recall_active(recall_active), .dirty_clr(dirty_clr)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_n(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Per-cycle comparison against the behavioural model, then model step.
    always @(negedge clk) begin
        if (run) begin
            int np, nl;
            bit ns, nc, start_rc;
            check("R7 port_off per-cycle",     port_off,      (m_ph == 0 || m_ph == 1 || m_ph == 4 || m_ph == 5));
            check("R8 busy_pull per-cycle",    busy_pull,     (m_ph == 4 || (m_ph == 3 && m_src)));
            check("R6 store_active per-cycle", store_active,  (m_ph == 4));
            check("R2 recall_active per-cycle",recall_active, (m_ph == 1));
            check("R4 dirty_clr per-cycle",    dirty_clr,     m_clr);
            np = m_ph; nl = m_left; ns = m_src; nc = 0; start_rc = 0;
            case (m_ph)
                0: if (supply_ok) begin
                       if (m_rq) begin np = 1; nl = RC; nc = 1; start_rc = 1; end
                       else np = 2;
                   end
                1: if (m_left == 1) np = 2; else nl = m_left - 1;
                2: if (!supply_ok) begin
                       if (!autostore_off) begin np = 3; nl = GR; ns = 1; end
                       else np = 0;
                   end else if (!busy_line) begin np = 3; nl = GR; ns = 0; end
                3: if (m_left == 1) begin
                       if (m_src && busy_line) np = 0;
                       else if (dirty) begin np = 4; nl = ST; nc = 1; end
                       else if (m_src) np = 0;
                       else begin np = 5; nl = RV; end
                   end else nl = m_left - 1;
                4: if (m_left == 1) begin
                       if (m_src) np = 0; else begin np = 5; nl = RV; end
                   end else nl = m_left - 1;
                5: if (!supply_ok) np = 0;
                   else if (!busy_line) nl = RV;
                   else if (m_left == 1) np = 2;
                   else nl = m_left - 1;
                default: np = 0;
            endcase
            if (supply_dead) m_rq = 1; else if (start_rc) m_rq = 0;
            m_ph = np; m_left = nl; m_src = ns; m_clr = nc;
            if (store_active) n_store++;
            if (recall_active) n_recall++;
            if (busy_pull && !store_active) n_pull++;
            if (dirty_clr) begin n_clr++; dirty = 0; end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s0, r0, p0, c0;
        tick(3);
        check("R1 port_off after reset", port_off, 1'b1);
        check("R1 busy_pull after reset", busy_pull, 1'b0);
        check("R1 copies idle after reset", store_active | recall_active | dirty_clr, 1'b0);
        rst_n = 1; run = 1;
        tick(2);
        check("R1 no recall without supply", recall_active, 1'b0);

        // Power-up recall
        r0 = n_recall; c0 = n_clr;
        supply_ok = 1;
        tick(RC + 5);
        check_n("R2 recall length", n_recall - r0, RC);
        check_n("R4 clear strobes per recall", n_clr - c0, 1);
        check("R2 port enabled after recall", port_off, 1'b0);

        // Line request, nothing written
        s0 = n_store;
        ext_low = 1; tick(2);
        check("R5 port usable in grace", port_off, 1'b0);
        check("R5 no pull in line grace", busy_pull, 1'b0);
        ext_low = 0; tick(GR + RV + 5);
        check_n("R6 no store when clean", n_store - s0, 0);
        check("R7 port back after recovery", port_off, 1'b0);

        // Line request with a write pending, line held low past the store
        s0 = n_store; c0 = n_clr;
        dirty = 1; ext_low = 1;
        tick(GR + ST + 5);
        check_n("R6 store length", n_store - s0, ST);
        check_n("R4 clear strobe per store", n_clr - c0, 1);
        check("R7 held off while line low", port_off, 1'b1);
        ext_low = 0; tick(1);
        check("R7 held during recovery", port_off, 1'b1);
        tick(RV + 3);
        check("R7 port back after release", port_off, 1'b0);

        // Supply drop with write pending
        s0 = n_store; r0 = n_recall;
        dirty = 1; supply_ok = 0; tick(2);
        check("R8 pull during supply grace", busy_pull, 1'b1);
        tick(GR + ST + 5);
        check_n("R13 supply store ran", n_store - s0, ST);
        check("R13 off after supply store", port_off, 1'b1);
        supply_ok = 1; tick(RC + 5);
        check_n("R3 shallow dip no recall", n_recall - r0, 0);
        check("R3 port back after dip", port_off, 1'b0);

        // Supply drop, clean
        s0 = n_store; p0 = n_pull;
        supply_ok = 0; tick(GR + 5);
        check_n("R8 pull window length", n_pull - p0, GR);
        check_n("R8 no store when clean", n_store - s0, 0);
        supply_ok = 1; tick(5);

        // Abort: line held high against the pull
        s0 = n_store;
        dirty = 1; hold_high = 1; supply_ok = 0;
        tick(GR + ST + 5);
        check_n("R9 aborted store", n_store - s0, 0);
        check("R9 off after abort", port_off, 1'b1);
        supply_ok = 1; hold_high = 0; tick(5);

        // Auto-store inhibited
        s0 = n_store; p0 = n_pull; r0 = n_recall;
        autostore_off = 1; supply_ok = 0;
        tick(GR + ST + 5);
        check_n("R10 no store when inhibited", n_store - s0, 0);
        check_n("R10 no pull when inhibited", n_pull - p0, 0);
        ext_low = 1; tick(GR + ST + 5);
        check_n("R11 line ignored at low supply", n_store - s0, 0);
        ext_low = 0; supply_dead = 1; tick(2);
        supply_dead = 0; supply_ok = 1; tick(RC + 5);
        check_n("R3 deep drop recall", n_recall - r0, RC);
        autostore_off = 0; tick(2);

        // Simultaneous triggers
        s0 = n_store; p0 = n_pull;
        dirty = 1; supply_ok = 0; ext_low = 1;
        tick(GR + ST + 5);
        check_n("R12 supply path pulls", n_pull - p0, GR);
        check_n("R12 store ran", n_store - s0, ST);
        ext_low = 0; tick(RV + 3);
        check("R12 still off at low supply", port_off, 1'b1);
        supply_ok = 1; tick(5);
        check("R12 port back", port_off, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule